// File: doc/BRIEF.md
# Serial Bus Channel Configuration Register Set

This block holds the settings of one serial bus channel behind a byte-wide register port: the short word length, the CRC length, a spread-spectrum control byte and a frequency offset byte. A host writes it through address, write-data and write-enable. It reads it back through a read-data bus that follows the address combinationally. Every written value is checked against its legal range and adjusted before it is stored. Bits that have no function read back as zero.

The bus engine does not see the stored values directly. It sees an active copy. That copy is loaded only when the engine pulses `xact_start` at the start of a bus transaction, so a setting changes only between transactions. Any write to the spread-spectrum byte also raises a one-cycle abort toward the engine. The active copy also carries the pseudo-random sequence length and its two feedback tap positions, decoded from the stored select code.

Top module: `ser_chan_cfg`

## Requirements
- R1: After reset, address 0 reads 0x40 and addresses 1 and 2 read 0x00. The active word length is 8, the active CRC length is 4, `abort_o` is 0, spread enable is 0, PLL-off is 0, and the sequence length is 6 with taps 5 and 4.
- R2: Address 0 bits [3:0] set the short word length. Only bits [2:0] are kept. The word length in effect is 8 plus those three bits, so values 8 to 15 result. A read of bit 3 always returns 0.
- R3: Address 0 bits [7:4] set the CRC length. A value from 0 to 8 is stored as written, and any value above 8 is stored as 8.
- R4: Address 1 is the spread-spectrum byte: enable at bit 6, PLL-off at bit 5, sequence select at bits 4:3 and deviation select at bits 2:1. Bits 7 and 0 are not stored and read as 0.
- R5: A write to address 1 makes `abort_o` high for exactly the cycle that follows the write edge, even when the value is unchanged. Writes to any other address never raise it.
- R6: Register writes do not change the active outputs. On a clock edge where `xact_start` is high, the active outputs take the stored values as they were before that edge. A write on the same edge is held back until the next `xact_start`.
- R7: Address 2 holds the frequency offset byte. A write to it is ignored while the stored PLL-off bit is 1.
- R8: The active sequence select decodes as follows: 0 gives length 6 with taps 5 and 4, 1 gives length 7 with taps 6 and 5, 2 gives length 11 with taps 10 and 8, and 3 gives length 15 with taps 14 and 13.
- R9: A write to any address other than 0, 1 or 2 changes nothing, and a read of such an address returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | AW | Register address |
| wdata | input | 8 | Write data |
| we | input | 1 | Write enable, sampled on the rising edge |
| rdata | output | 8 | Read data for `addr` |
| xact_start | input | 1 | Transaction start strobe from the bus engine |
| abort_o | output | 1 | One-cycle abort request |
| act_wlen | output | 4 | Active short word length (8 to 15) |
| act_crc_len | output | 4 | Active CRC length (0 to 8) |
| act_ss_en | output | 1 | Active spread-spectrum enable |
| act_pll_off | output | 1 | Active PLL-off flag |
| act_dev_sel | output | 2 | Active deviation select |
| act_prbs_len | output | 4 | Active sequence register length |
| act_tap_a | output | 4 | Active first feedback tap position |
| act_tap_b | output | 4 | Active second feedback tap position |
| act_freq_ofs | output | 8 | Active frequency offset |

## Verification
A corrupted stored field shows up on `rdata` in the same cycle its address is presented, and on the active outputs one edge after the next `xact_start`. A staging fault shows up as active outputs that move on a plain write, or that pick up a write made on the same edge as the strobe. The bench reads back after each write and probes the active outputs both before and after each strobe. Clamping faults appear as soon as the read-back is taken, the missing frequency offset lock as a changed read of address 2, and abort faults within one cycle of the write.

// File: rtl/ser_chan_cfg.sv
module ser_chan_cfg #(
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    wdata,
  input  logic          we,
  output logic [7:0]    rdata,
  input  logic          xact_start,
  output logic          abort_o,
  output logic [3:0]    act_wlen,
  output logic [3:0]    act_crc_len,
  output logic          act_ss_en,
  output logic          act_pll_off,
  output logic [1:0]    act_dev_sel,
  output logic [3:0]    act_prbs_len,
  output logic [3:0]    act_tap_a,
  output logic [3:0]    act_tap_b,
  output logic [7:0]    act_freq_ofs
);
  localparam logic [AW-1:0] A_LEN  = AW'(0);
  localparam logic [AW-1:0] A_SPRD = AW'(1);
  localparam logic [AW-1:0] A_FOFS = AW'(2);
  localparam logic [3:0]    CRC_MAX = 4'd8;
  localparam logic [3:0]    CRC_RST = 4'd4;

  logic [2:0] wl_q;
  logic [3:0] crc_q;
  logic       en_q, poff_q;
  logic [1:0] sel_q, dev_q;
  logic [7:0] fofs_q;
  logic [2:0] act_wl;
  logic [1:0] act_sel;

  wire wr_len  = we && (addr == A_LEN);
  wire wr_sprd = we && (addr == A_SPRD);
  wire wr_fofs = we && (addr == A_FOFS);
  wire [3:0] crc_in = (wdata[7:4] > CRC_MAX) ? CRC_MAX : wdata[7:4];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wl_q    <= '0;
      crc_q   <= CRC_RST;
      en_q    <= 1'b0;
      poff_q  <= 1'b0;
      sel_q   <= '0;
      dev_q   <= '0;
      fofs_q  <= '0;
      abort_o <= 1'b0;
    end else begin
      abort_o <= wr_sprd;
      if (wr_len) begin
        wl_q  <= wdata[2:0];
        crc_q <= crc_in;
      end
      if (wr_sprd) begin
        en_q   <= wdata[6];
        poff_q <= wdata[5];
        sel_q  <= wdata[4:3];
        dev_q  <= wdata[2:1];
      end
      if (wr_fofs && !poff_q) fofs_q <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_wl       <= '0;
      act_crc_len  <= CRC_RST;
      act_ss_en    <= 1'b0;
      act_pll_off  <= 1'b0;
      act_sel      <= '0;
      act_dev_sel  <= '0;
      act_freq_ofs <= '0;
    end else if (xact_start) begin
      act_wl       <= wl_q;
      act_crc_len  <= crc_q;
      act_ss_en    <= en_q;
      act_pll_off  <= poff_q;
      act_sel      <= sel_q;
      act_dev_sel  <= dev_q;
      act_freq_ofs <= fofs_q;
    end
  end

  assign act_wlen = {1'b1, act_wl};

  always_comb begin
    case (act_sel)
      2'd0:    begin act_prbs_len = 4'd6;  act_tap_a = 4'd5;  act_tap_b = 4'd4;  end
      2'd1:    begin act_prbs_len = 4'd7;  act_tap_a = 4'd6;  act_tap_b = 4'd5;  end
      2'd2:    begin act_prbs_len = 4'd11; act_tap_a = 4'd10; act_tap_b = 4'd8;  end
      default: begin act_prbs_len = 4'd15; act_tap_a = 4'd14; act_tap_b = 4'd13; end
    endcase
  end

  always_comb begin
    case (addr)
      A_LEN:   rdata = {crc_q, 1'b0, wl_q};
      A_SPRD:  rdata = {1'b0, en_q, poff_q, sel_q, dev_q, 1'b0};
      A_FOFS:  rdata = fofs_q;
      default: rdata = 8'h00;
    endcase
  end

  p_crc_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    act_crc_len <= CRC_MAX);

  p_abort_src_r5: assert property (@(posedge clk) disable iff (!rst_n)
    abort_o |-> $past(we && addr == A_SPRD));

  p_abort_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (we && addr == A_SPRD) |=> abort_o);

  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !xact_start |=> $stable({act_wlen, act_crc_len, act_ss_en, act_pll_off,
                             act_dev_sel, act_prbs_len, act_freq_ofs}));

  p_ofs_lock_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (we && addr == A_FOFS && poff_q) |=> $stable(fofs_q));

  p_dead_bits_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == A_SPRD) |-> (rdata[7] == 1'b0 && rdata[0] == 1'b0));
endmodule

// File: tb/test_ser_chan_cfg.sv
module test_ser_chan_cfg;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] addr = '0;
  logic [7:0] wdata = '0;
  logic       we = 1'b0;
  logic       xact_start = 1'b0;
  logic [7:0] rdata;
  logic       abort_o, act_ss_en, act_pll_off;
  logic [3:0] act_wlen, act_crc_len, act_prbs_len, act_tap_a, act_tap_b;
  logic [1:0] act_dev_sel;
  logic [7:0] act_freq_ofs;
  int vectors = 0;
  int miscompares = 0;

  always #10 clk = ~clk;

  ser_chan_cfg #(.AW(4)) i_ser_chan_cfg (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .we(we),
    .rdata(rdata), .xact_start(xact_start), .abort_o(abort_o),
    .act_wlen(act_wlen), .act_crc_len(act_crc_len), .act_ss_en(act_ss_en),
    .act_pll_off(act_pll_off), .act_dev_sel(act_dev_sel),
    .act_prbs_len(act_prbs_len), .act_tap_a(act_tap_a), .act_tap_b(act_tap_b),
    .act_freq_ofs(act_freq_ofs));

  task automatic chk(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d, input logic x);
    @(negedge clk);
    addr = a; wdata = d; we = 1'b1; xact_start = x;
    @(negedge clk);
    we = 1'b0; xact_start = 1'b0;
  endtask

  task automatic rd(input string req, input logic [3:0] a, input logic [7:0] exp);
    addr = a;
    #1;
    chk(req, rdata, exp);
  endtask

  task automatic strobe();
    @(negedge clk);
    xact_start = 1'b1;
    @(negedge clk);
    xact_start = 1'b0;
  endtask

  task automatic t_reset();
    rd("R1 addr0", 4'd0, 8'h40);
    rd("R1 addr1", 4'd1, 8'h00);
    rd("R1 addr2", 4'd2, 8'h00);
    chk("R1 wlen", act_wlen, 8);
    chk("R1 crc", act_crc_len, 4);
    chk("R1 abort", abort_o, 0);
    chk("R1 en/poff", {act_ss_en, act_pll_off}, 0);
    chk("R1 prbs", {act_prbs_len, act_tap_a, act_tap_b}, 12'h654);
  endtask

  task automatic t_wlen();
    wr(4'd0, 8'h03, 1'b0);
    rd("R2 readback top bit 0", 4'd0, 8'h03);
    chk("R6 wlen held before strobe", act_wlen, 8);
    strobe();
    chk("R2 wlen 3 -> 11", act_wlen, 11);
    chk("R3 crc 0 stored", act_crc_len, 0);
    wr(4'd0, 8'h8F, 1'b0);
    rd("R2 wlen 15 readback", 4'd0, 8'h87);
    strobe();
    chk("R2 wlen 15", act_wlen, 15);
    chk("R3 crc 8 stored", act_crc_len, 8);
  endtask

  task automatic t_crc();
    wr(4'd0, 8'hF5, 1'b0);
    rd("R3 crc 15 clamped", 4'd0, 8'h85);
    wr(4'd0, 8'h90, 1'b0);
    rd("R3 crc 9 clamped", 4'd0, 8'h80);
    wr(4'd0, 8'h62, 1'b0);
    rd("R3 crc 6 kept", 4'd0, 8'h62);
    strobe();
    chk("R3 active crc 6", act_crc_len, 6);
    chk("R2 active wlen 10", act_wlen, 10);
  endtask

  task automatic t_sprd();
    wr(4'd1, 8'hFF, 1'b0);
    chk("R5 abort after write", abort_o, 1);
    rd("R4 dead bits read 0", 4'd1, 8'h7E);
    @(negedge clk);
    chk("R5 abort one cycle", abort_o, 0);
    chk("R6 ss held before strobe", {act_ss_en, act_pll_off, act_dev_sel}, 0);
    strobe();
    chk("R4 ss fields active", {act_ss_en, act_pll_off, act_dev_sel}, 4'hF);
    chk("R8 sel 3", {act_prbs_len, act_tap_a, act_tap_b}, 12'hFED);
    wr(4'd1, 8'h7E, 1'b0);
    chk("R5 abort on unchanged value", abort_o, 1);
  endtask

  task automatic t_fofs();
    wr(4'd2, 8'h5A, 1'b0);
    chk("R5 no abort on addr2", abort_o, 0);
    rd("R7 write ignored with pll-off", 4'd2, 8'h00);
    wr(4'd1, 8'h00, 1'b0);
    wr(4'd2, 8'h5A, 1'b0);
    rd("R7 write accepted", 4'd2, 8'h5A);
    chk("R6 ofs held before strobe", act_freq_ofs, 0);
    strobe();
    chk("R7 active ofs", act_freq_ofs, 8'h5A);
  endtask

  task automatic t_prbs();
    for (int s = 0; s < 4; s++) begin
      logic [11:0] e;
      case (s)
        0: e = 12'h654;
        1: e = 12'h765;
        2: e = 12'hBA8;
        default: e = 12'hFED;
      endcase
      wr(4'd1, 8'(s << 3), 1'b0);
      strobe();
      chk("R8 decode", {act_prbs_len, act_tap_a, act_tap_b}, e);
    end
  endtask

  task automatic t_same_edge();
    wr(4'd1, 8'h10, 1'b1);
    chk("R6 same-edge write held back", act_prbs_len, 15);
    strobe();
    chk("R6 applied next strobe", act_prbs_len, 11);
  endtask

  task automatic t_unmapped();
    wr(4'd5, 8'hFF, 1'b0);
    chk("R9 no abort", abort_o, 0);
    rd("R9 read 0", 4'd5, 8'h00);
    rd("R9 addr0 unchanged", 4'd0, 8'h62);
    rd("R9 addr1 unchanged", 4'd1, 8'h10);
    rd("R9 addr2 unchanged", 4'd2, 8'h5A);
  endtask

  initial begin
    #(20 * 150000);
    miscompares++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_wlen();
    t_crc();
    t_sprd();
    t_fofs();
    t_prbs();
    t_same_edge();
    t_unmapped();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule